// File: doc/BRIEF.md
# Dual-Mode Watchdog / Interval Timer

This block is an 8-bit up-counter. Its tick comes from a prescaler that divides the system clock by one of eight ratios. When the counter wraps from 0xFF to 0x00, the block either raises an interrupt request toward the processor (interval mode) or drives a fixed-length pulse on an external overflow pin (watchdog mode). Which of the two happens depends on a mode bit. In both modes the wrap sets a sticky overflow flag. Software clears that flag with a read-then-write sequence.

Software reaches the block through a small synchronous register port with two addresses. Address 0 is the control/status register. Address 1 is the count register. Software can reload the count register at any time, and this is how a watchdog is kept from expiring. Clearing the enable bit holds the counter and the prescaler at zero.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the control register reads 0x18, the count register reads 0x00, and `irq_req` and `wdog_ovf` are both low.
- R2: While the enable bit (control bit 5) is 0, the count register is held at 0x00, does not advance, and ignores writes.
- R3: Control bits 4 and 3 always read as 1, and writes to them have no effect. Bit 6 (mode), bit 5 (enable) and bits 2..0 (clock select) read back as written.
- R4: Clock select 0..7 picks the tick ratio /2, /64, /128, /256, /512, /1024, /4096 or /8192. Once enabled from zero, the count equals floor(edges since the enabling write / ratio).
- R5: The count wraps from 0xFF to 0x00 on the 256th tick. The same edge sets control bit 7 (the overflow flag).
- R6: In interval mode (bit 6 = 0), `irq_req` equals the overflow flag. It stays high until the flag is cleared.
- R7: In watchdog mode (bit 6 = 1), `wdog_ovf` goes high on the overflow edge and stays high for exactly 128 clocks, while `irq_req` stays low.
- R8: A write of 0 to bit 7 clears the flag only if the flag was read as 1 beforehand. Writing 1 to bit 7 never sets the flag, and a write of 0 without a prior read leaves it set. An overflow in the same cycle as a clear wins.
- R9: A write to the count register while enabled takes effect on that edge, overriding any tick. Periodic reloads keep the counter from wrapping.
- R10: The prescaler is cleared while the timer is disabled, so the first tick after enabling comes a full ratio of clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_cs | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 1 | 0 = control/status, 1 = count |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from the addressed register) |
| irq_req | output | 1 | Interval-mode interrupt request |
| wdog_ovf | output | 1 | Watchdog overflow pulse |

## Verification
A register write takes effect on the edge that samples it. A count of k ticks therefore shows up k×ratio edges after the enabling edge, and the wrap and flag appear together on edge 256×ratio. `irq_req` follows the flag with no added delay. `wdog_ovf` rises on the overflow edge and falls 128 edges later. Clearing the enable bit zeroes the count one edge after the write. The bench drives inputs on falling edges and counts rising edges from the end of each write task. It reads the count or control value combinationally in the same low phase, so no extra edge passes and a probe read never arms the flag clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PRE_W = 13;

  // log2 of the divide ratio for each clock-select code
  function automatic int unsigned div_shift(input logic [2:0] code);
    if (code == 3'd0)      return 1;
    else if (code <= 3'd5) return int'(code) + 5;
    else                   return int'(code) + 6;
  endfunction

  function automatic logic [PRE_W-1:0] tick_mask(input logic [2:0] code);
    return PRE_W'((1 << div_shift(code)) - 1);
  endfunction

  typedef enum logic {MODE_INTERVAL = 1'b0, MODE_WATCHDOG = 1'b1} wdt_mode_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;

  assign mask = tick_mask(sel);
  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         wrap
);
  assign wrap = run && tick && !load && (count == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n || !run) count <= '0;
    else if (load)      count <= load_val;
    else if (tick)      count <= count + 1'b1;
  end
endmodule

// File: rtl/wdt_stretch.sv
module wdt_stretch #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] left_q;

  assign pulse = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             left_q <= '0;
    else if (trig)          left_q <= CW'(LEN);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_cs,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq_req,
  output logic             wdog_ovf
);
  wdt_mode_e  mode_q;
  logic       en_q;
  logic [2:0] sel_q;
  logic       flag_q;
  logic       armed_q;

  logic             ctrl_wr, ctrl_rd, cnt_wr;
  logic             tick, ovf_evt, clr_evt;
  logic [CNT_W-1:0] count;

  assign ctrl_wr = reg_cs && reg_we && !reg_addr;
  assign ctrl_rd = reg_cs && !reg_we && !reg_addr;
  assign cnt_wr  = reg_cs && reg_we && reg_addr && en_q;
  assign clr_evt = ctrl_wr && !reg_wdata[7] && armed_q && flag_q;

  wdt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(en_q), .sel(sel_q), .tick(tick)
  );

  wdt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(en_q), .tick(tick), .load(cnt_wr),
    .load_val(reg_wdata), .count(count), .wrap(ovf_evt)
  );

  wdt_stretch #(.LEN(PULSE_LEN)) u_str (
    .clk(clk), .rst_n(rst_n), .trig(ovf_evt && (mode_q == MODE_WATCHDOG)),
    .pulse(wdog_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_INTERVAL;
      en_q   <= 1'b0;
      sel_q  <= 3'd0;
    end else if (ctrl_wr) begin
      mode_q <= wdt_mode_e'(reg_wdata[6]);
      en_q   <= reg_wdata[5];
      sel_q  <= reg_wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (ovf_evt)      flag_q <= 1'b1;
      else if (clr_evt) flag_q <= 1'b0;
      if (clr_evt)                 armed_q <= 1'b0;
      else if (ctrl_rd && flag_q)  armed_q <= 1'b1;
    end
  end

  always_comb begin
    if (reg_addr) reg_rdata = count;
    else          reg_rdata = {flag_q, mode_q, en_q, 2'b11, sel_q};
  end

  assign irq_req = flag_q && (mode_q == MODE_INTERVAL);
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_q,
  input logic       mode_q,
  input logic       flag_q,
  input logic       tick,
  input logic       cnt_wr,
  input logic       ovf_evt,
  input logic       clr_evt,
  input logic       ctrl_rd,
  input logic [7:0] count,
  input logic [7:0] reg_rdata,
  input logic       irq_req,
  input logic       wdog_ovf
);
  // R2
  disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> count == 8'd0);
  // R4
  tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && tick && !cnt_wr |=> count == 8'($past(count) + 8'd1));
  // R5
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag_q && count == 8'd0);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_evt |=> flag_q);
  // R6
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !mode_q |=> irq_req);
  // R7
  wdog_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && mode_q |=> wdog_ovf && !irq_req);
  // R3
  reserved_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |-> reg_rdata[4:3] == 2'b11);
endmodule

bind wdt_timer wdt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .mode_q(mode_q), .flag_q(flag_q),
  .tick(tick), .cnt_wr(cnt_wr), .ovf_evt(ovf_evt), .clr_evt(clr_evt),
  .ctrl_rd(ctrl_rd), .count(count), .reg_rdata(reg_rdata),
  .irq_req(irq_req), .wdog_ovf(wdog_ovf)
);

// File: tb/wdt_timer_test.sv
module wdt_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_cs = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq_req;
  logic       wdog_ovf;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  wdt_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_cs(reg_cs), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .wdog_ovf(wdog_ovf)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ratio_of(input logic [2:0] c);
    int tbl[8] = '{2, 64, 128, 256, 512, 1024, 4096, 8192};
    return tbl[c];
  endfunction

  function automatic int exp_count(input int edges, input logic [2:0] c);
    return (edges / ratio_of(c)) % 256;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_cs = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_cs = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd_arm();
    reg_cs = 1'b1; reg_we = 1'b0; reg_addr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    reg_cs = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] v);
    reg_cs = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
    reg_cs = 1'b0;
  endtask

  task automatic wait_e(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc >= 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] d;
    void'($urandom(32'd4711));
    wait_e(4);
    rst_n = 1'b1;
    wait_e(1);

    // R1 reset state
    peek(1'b0, v); chk("R1 ctrl", v, 8'h18);
    peek(1'b1, v); chk("R1 count", v, 8'h00);
    chk("R1 irq", irq_req, 0);
    chk("R1 wdog", wdog_ovf, 0);

    // R3 / R8 random control writes with timer off; bit 7 write never sets flag
    for (int i = 0; i < 4; i++) begin
      d = 8'($urandom) & 8'hDF;
      wr(1'b0, d);
      peek(1'b0, v);
      chk("R3 ctrl readback", v, {1'b0, d[6], 1'b0, 2'b11, d[2:0]});
    end

    // R2 count write ignored while disabled
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h55);
    peek(1'b1, v); chk("R2 write ignored", v, 0);

    // R4 random ratios
    for (int t = 0; t < 5; t++) begin
      logic [2:0] c;
      int n;
      c = 3'($urandom);
      n = int'($urandom % (2 * ratio_of(c) + 3));
      wr(1'b0, {5'b00100, c});
      wait_e(n);
      peek(1'b1, v);
      chk("R4 count vs ratio", v, exp_count(n, c));
      wr(1'b0, 8'h00);
    end

    // R10 / R2 prescaler restart
    wr(1'b0, 8'h21);
    wait_e(100);
    peek(1'b1, v); chk("R4 /64 count", v, 1);
    wr(1'b0, 8'h01);
    wait_e(1);
    peek(1'b1, v); chk("R2 forced zero", v, 0);
    wait_e(10);
    peek(1'b1, v); chk("R2 no advance", v, 0);
    wr(1'b0, 8'h21);
    wait_e(63);
    peek(1'b1, v); chk("R10 before first tick", v, 0);
    wait_e(1);
    peek(1'b1, v); chk("R10 first tick", v, 1);

    // R9 write overrides
    wr(1'b1, 8'hF0);
    peek(1'b1, v); chk("R9 load", v, 8'hF0);
    wr(1'b0, 8'h00);

    // R5 / R6 interval overflow at /2
    wr(1'b0, 8'h20);
    wait_e(511);
    peek(1'b1, v); chk("R5 pre-wrap count", v, 8'hFF);
    chk("R6 irq before wrap", irq_req, 0);
    wait_e(1);
    peek(1'b1, v); chk("R5 wrapped count", v, 0);
    peek(1'b0, v); chk("R5 flag set", v, 8'hB8);
    chk("R6 irq raised", irq_req, 1);
    chk("R6 no wdog", wdog_ovf, 0);

    // R8 clear protocol
    wr(1'b0, 8'h20);
    peek(1'b0, v); chk("R8 no clear without read", v, 8'hB8);
    wait_e(50);
    chk("R6 irq held", irq_req, 1);
    rd_arm();
    wr(1'b0, 8'hA0);
    peek(1'b0, v); chk("R8 write 1 no clear", v, 8'hB8);
    wr(1'b0, 8'h20);
    peek(1'b0, v); chk("R8 cleared", v, 8'h38);
    chk("R6 irq dropped", irq_req, 0);

    // R7 watchdog pulse
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h60);
    wait_e(511);
    chk("R7 low before wrap", wdog_ovf, 0);
    wait_e(1);
    chk("R7 wdog high", wdog_ovf, 1);
    chk("R7 irq low", irq_req, 0);
    wait_e(127);
    chk("R7 last pulse cycle", wdog_ovf, 1);
    wait_e(1);
    chk("R7 pulse end", wdog_ovf, 0);

    // R9 reload keeps watchdog from expiring (flag cleared first)
    rd_arm();
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h60);
    for (int k = 0; k < 4; k++) begin
      wait_e(300);
      wr(1'b1, 8'h00);
      chk("R9 no expiry", wdog_ovf, 0);
    end
    peek(1'b0, v); chk("R9 flag clear", v, 8'h78);

    finish_run();
  end
endmodule